// File: doc/BRIEF.md
# Execute-in-Place Access Security Filter

This block stands between a system bus port and the cache and serial-flash back end of an execute-in-place memory system. It classifies each incoming access from two address bits and the secure or non-secure attribute of the requester. Each access gets exactly one outcome: a cache lookup, a direct flash access that bypasses the cache, a cache maintenance operation, or a bus error. For cache lookups the block also names the cache ways the access may use. For memory windows that are not writable, it turns writes into reads.

The block holds the control register that sets all of these rules. That register has per-world cache enables, per-world window blocking bits, a maintenance permit for non-secure code, a way-split bit, two per-window write permits and a power-down bit that interlocks the cache enables. The decision is registered and appears one cycle after the request is presented. The cache arrays, the tag lookup and the flash serial engine are outside this block and only consume its outputs.

Top module: `xip_access_filter`

## Requirements
- R1: After reset the control register reads as all zeros, and `rsp_valid` is 0 until a request is presented.
- R2: A control write stores the written value, with one exception. If bit 2 (power-down) of the written value is 1, bits 0 (secure cache enable) and 1 (non-secure cache enable) are stored as 0. The other control bits are: 3 and 4 block the uncached window for secure and non-secure accesses; 5 and 6 block the raw (uncached, untranslated) window for secure and non-secure accesses; 7 permits non-secure maintenance; 8 splits the ways; 9 and 10 make memory windows 0 and 1 writable.
- R3: `rsp_valid` is 1 in the cycle after a cycle with `req_valid` 1, and 0 in the cycle after a cycle with `req_valid` 0. All outcome outputs are 0 when `rsp_valid` is 0.
- R4: Address bits [27:26] select the window: 0 cached, 1 uncached, 2 maintenance, 3 raw. An access to the cached window queries the cache when the cache enable of its own world is 1. Otherwise it goes to flash.
- R5: Accesses to the uncached and raw windows never query the cache, whatever the enables are. They go to flash unless they are blocked.
- R6: An access to the uncached window gets a bus error when the uncached-block bit of its own world is 1. An access to the raw window gets a bus error when the raw-block bit of its own world is 1.
- R7: A non-secure access to the maintenance window gets a bus error unless the maintenance permit is 1. Otherwise a maintenance access is flagged on `rsp_maint`.
- R8: For a cache query, `rsp_way_mask` has all ways set when split is 0. When split is 1, it has only way 0 for secure accesses and only way 1 for non-secure accesses. The mask is 0 for any access that is not a cache query.
- R9: Address bit 25 = 0 selects memory window 0 or 1 by bit 24. Bit 25 = 1 is not writable. A write to the uncached, raw or cached window leaves as a write only if its memory window is writable; otherwise it leaves as a read. A maintenance write stays a write.
- R10: Exactly one of `rsp_buserr`, `rsp_cache_query`, `rsp_flash_req` and `rsp_maint` is 1 for each response. A bus error carries no way mask and no write.
- R11: While power-down is 1, no access queries the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 11 | Control register write value |
| cfg_rdata | output | 11 | Control register contents |
| req_valid | input | 1 | Access request present |
| req_addr | input | 28 | Access address |
| req_write | input | 1 | Access is a write |
| req_secure | input | 1 | Access comes from the secure world |
| rsp_valid | output | 1 | Classification valid |
| rsp_buserr | output | 1 | Access returns a bus error |
| rsp_cache_query | output | 1 | Access queries the cache |
| rsp_flash_req | output | 1 | Access bypasses the cache to flash |
| rsp_maint | output | 1 | Access is a cache maintenance operation |
| rsp_way_mask | output | 2 | Cache ways the access may use |
| rsp_write | output | 1 | Access direction after downgrade |

## Verification
The assertions assume that each response comes from the control value held in the cycle the request was taken. This means the bench never writes the control register and presents a request in the same cycle. The stimulus loads every one of the 2048 control values, and it presents requests only after the write has settled. Under each control value it sweeps every combination of window, memory window index, world and direction, one request per cycle. Each outcome is predicted from the requirement rules.

// File: rtl/xip_filter_pkg.sv
// Package: shared widths, control bit positions and the route record for
// the execute-in-place access filter. Assumes a two-bit window field at the
// top of the address.
package xip_filter_pkg;
    localparam int CTRL_W      = 11;
    localparam int B_EN_SEC    = 0;
    localparam int B_EN_NS     = 1;
    localparam int B_PWR_DOWN  = 2;
    localparam int B_BLK_UNC_S = 3;
    localparam int B_BLK_UNC_N = 4;
    localparam int B_BLK_RAW_S = 5;
    localparam int B_BLK_RAW_N = 6;
    localparam int B_MAINT_NS  = 7;
    localparam int B_SPLIT     = 8;
    localparam int B_WR_M0     = 9;
    localparam int B_WR_M1     = 10;

    typedef enum logic [1:0] {
        WIN_CACHED   = 2'd0,
        WIN_UNCACHED = 2'd1,
        WIN_MAINT    = 2'd2,
        WIN_RAW      = 2'd3
    } win_e;

    typedef struct packed {
        logic buserr;
        logic query;
        logic flash;
        logic maint;
        logic write;
    } route_t;
endpackage

// File: rtl/xip_ctrl_reg.sv
// Control register for the access filter. It captures writes. A write with
// power-down set stores both cache enables as zero. Assumes the writer
// drives cfg_we for one cycle for each update.
module xip_ctrl_reg
    import xip_filter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] ctrl_q
);
    logic [CTRL_W-1:0] wr_val;

    // Apply the power-down interlock to the incoming value.
    always_comb begin
        wr_val = cfg_wdata;
        if (cfg_wdata[B_PWR_DOWN]) begin
            wr_val[B_EN_SEC] = 1'b0;
            wr_val[B_EN_NS]  = 1'b0;
        end
    end

    // Hold the control value; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (cfg_we) ctrl_q <= wr_val;
    end
endmodule

// File: rtl/xip_window_decode.sv
// Combinational classifier. It maps the window bits, the world and the
// control bits to one outcome, a way mask and a final direction. Assumes
// NUM_WAYS is even when the split is used.
module xip_window_decode
    import xip_filter_pkg::*;
#(
    parameter int ADDR_W   = 28,
    parameter int NUM_WAYS = 2
) (
    input  logic [CTRL_W-1:0]   ctrl,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                write,
    input  logic                secure,
    output route_t              route,
    output logic [NUM_WAYS-1:0] way_mask
);
    localparam int WIN_LSB  = ADDR_W - 2;
    localparam int MEM_LSB  = ADDR_W - 4;
    localparam int HALF     = NUM_WAYS / 2;

    win_e                win;
    logic                blocked;
    logic                enabled;
    logic                mem_writable;
    logic [NUM_WAYS-1:0] sec_ways;
    logic [NUM_WAYS-1:0] ns_ways;

    assign win = win_e'(addr[WIN_LSB +: 2]);

    // Build the per-world way halves.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign sec_ways[w] = (w < HALF);
        assign ns_ways[w]  = (w >= HALF);
    end

    // Decide whether the window is blocked for this world.
    always_comb begin
        unique case (win)
            WIN_UNCACHED: blocked = secure ? ctrl[B_BLK_UNC_S] : ctrl[B_BLK_UNC_N];
            WIN_RAW:      blocked = secure ? ctrl[B_BLK_RAW_S] : ctrl[B_BLK_RAW_N];
            WIN_MAINT:    blocked = !secure && !ctrl[B_MAINT_NS];
            default:      blocked = 1'b0;
        endcase
    end

    // Pick the cache enable and the write permit of the memory window.
    always_comb begin
        enabled      = secure ? ctrl[B_EN_SEC] : ctrl[B_EN_NS];
        mem_writable = !addr[MEM_LSB + 1] &&
                       (addr[MEM_LSB] ? ctrl[B_WR_M1] : ctrl[B_WR_M0]);
    end

    // Form the single outcome, the direction and the allowed ways.
    always_comb begin
        route        = '0;
        way_mask     = '0;
        route.buserr = blocked;
        if (!blocked) begin
            route.query = (win == WIN_CACHED) && enabled;
            route.maint = (win == WIN_MAINT);
            route.flash = !route.query && !route.maint;
            route.write = write && (route.maint || mem_writable);
            if (route.query) begin
                if (!ctrl[B_SPLIT]) way_mask = '1;
                else                way_mask = secure ? sec_ways : ns_ways;
            end
        end
    end
endmodule

// File: rtl/xip_route_reg.sv
// Output stage. It registers the classification so that it is valid one
// cycle after the request. It drives all outcome outputs to zero when no
// request was taken.
module xip_route_reg
    import xip_filter_pkg::*;
#(
    parameter int NUM_WAYS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  route_t              in_route,
    input  logic [NUM_WAYS-1:0] in_ways,
    output logic                out_valid,
    output route_t              out_route,
    output logic [NUM_WAYS-1:0] out_ways
);
    // Capture one classification per cycle, zeroed when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_route <= '0;
            out_ways  <= '0;
        end else begin
            out_valid <= in_valid;
            out_route <= in_valid ? in_route : '0;
            out_ways  <= in_valid ? in_ways  : '0;
        end
    end
endmodule

// File: rtl/xip_access_filter.sv
// Top of the execute-in-place access filter. It combines the control
// register, the window classifier and the output register. Assumes that at
// most one request is presented per cycle and that it is always accepted.
module xip_access_filter
    import xip_filter_pkg::*;
#(
    parameter int ADDR_W   = 28,
    parameter int NUM_WAYS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CTRL_W-1:0]   cfg_wdata,
    output logic [CTRL_W-1:0]   cfg_rdata,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_write,
    input  logic                req_secure,
    output logic                rsp_valid,
    output logic                rsp_buserr,
    output logic                rsp_cache_query,
    output logic                rsp_flash_req,
    output logic                rsp_maint,
    output logic [NUM_WAYS-1:0] rsp_way_mask,
    output logic                rsp_write
);
    logic [CTRL_W-1:0]   ctrl;
    route_t              dec_route;
    logic [NUM_WAYS-1:0] dec_ways;
    route_t              reg_route;

    xip_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ctrl_q    (ctrl)
    );

    xip_window_decode #(.ADDR_W(ADDR_W), .NUM_WAYS(NUM_WAYS)) u_dec (
        .ctrl     (ctrl),
        .addr     (req_addr),
        .write    (req_write),
        .secure   (req_secure),
        .route    (dec_route),
        .way_mask (dec_ways)
    );

    xip_route_reg #(.NUM_WAYS(NUM_WAYS)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_route  (dec_route),
        .in_ways   (dec_ways),
        .out_valid (rsp_valid),
        .out_route (reg_route),
        .out_ways  (rsp_way_mask)
    );

    assign cfg_rdata       = ctrl;
    assign rsp_buserr      = reg_route.buserr;
    assign rsp_cache_query = reg_route.query;
    assign rsp_flash_req   = reg_route.flash;
    assign rsp_maint       = reg_route.maint;
    assign rsp_write       = reg_route.write;
endmodule

// File: rtl/xip_access_filter_chk.sv
// Checker for the access filter. It relates the responses to the request
// and control values of the previous cycle. It is attached to every
// instance by the bind below.
module xip_access_filter_chk
    import xip_filter_pkg::*;
#(
    parameter int ADDR_W   = 28,
    parameter int NUM_WAYS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CTRL_W-1:0]   cfg_rdata,
    input logic                req_valid,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                req_secure,
    input logic                rsp_valid,
    input logic                rsp_buserr,
    input logic                rsp_cache_query,
    input logic                rsp_flash_req,
    input logic                rsp_maint,
    input logic [NUM_WAYS-1:0] rsp_way_mask,
    input logic                rsp_write
);
    localparam int WIN_LSB = ADDR_W - 2;

    assert_pd_clears_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[B_PWR_DOWN] |-> !cfg_rdata[B_EN_SEC] && !cfg_rdata[B_EN_NS]);

    assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_buserr || rsp_cache_query || rsp_flash_req || rsp_maint || rsp_write));

    assert_uncached_no_query_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_addr[WIN_LSB] |=> !rsp_cache_query);

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_buserr, rsp_cache_query, rsp_flash_req, rsp_maint}) == 1);

    assert_err_no_side_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_buserr |-> rsp_way_mask == '0 && !rsp_write);

    assert_split_one_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cfg_rdata[B_SPLIT] && req_secure |=> rsp_way_mask[NUM_WAYS-1] == 1'b0);

    assert_pd_no_query_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cfg_rdata[B_PWR_DOWN] |=> !rsp_cache_query);
endmodule

bind xip_access_filter xip_access_filter_chk #(.ADDR_W(ADDR_W), .NUM_WAYS(NUM_WAYS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_rdata       (cfg_rdata),
    .req_valid       (req_valid),
    .req_addr        (req_addr),
    .req_secure      (req_secure),
    .rsp_valid       (rsp_valid),
    .rsp_buserr      (rsp_buserr),
    .rsp_cache_query (rsp_cache_query),
    .rsp_flash_req   (rsp_flash_req),
    .rsp_maint       (rsp_maint),
    .rsp_way_mask    (rsp_way_mask),
    .rsp_write       (rsp_write)
);

// File: tb/xip_access_filter_tb.sv
// Bench: loads every control value, then sweeps window, memory index,
// world and direction under each one, one request per cycle.
module xip_access_filter_tb;
    localparam int AW = 28;
    localparam int CW = 11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [CW-1:0] cfg_wdata;
    logic [CW-1:0] cfg_rdata;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          req_write;
    logic          req_secure;
    logic          rsp_valid, rsp_buserr, rsp_cache_query, rsp_flash_req, rsp_maint, rsp_write;
    logic [1:0]    rsp_way_mask;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    xip_access_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_secure(req_secure), .rsp_valid(rsp_valid),
        .rsp_buserr(rsp_buserr), .rsp_cache_query(rsp_cache_query),
        .rsp_flash_req(rsp_flash_req), .rsp_maint(rsp_maint),
        .rsp_way_mask(rsp_way_mask), .rsp_write(rsp_write)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_secure = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset control", 32'(cfg_rdata), 32'h0);
        chk("R1 reset valid", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle valid", 32'(rsp_valid), 32'h0);
        for (int c = 0; c < 2048; c++) begin
            logic [CW-1:0] m;
            m = CW'(c);
            if (m[2]) m[1:0] = 2'b00;
            cfg_we = 1'b1; cfg_wdata = CW'(c);
            @(negedge clk);
            cfg_we = 1'b0;
            chk("R2 control readback", 32'(cfg_rdata), 32'(m));
            for (int p = 0; p < 64; p++) begin
                logic [1:0] win, idx, ways;
                logic sec, wr, en, blk, err, qry, mnt, fls, wok, wout;
                win = 2'(p >> 4); idx = 2'(p >> 2); sec = p[1]; wr = p[0];
                req_valid = 1'b1; req_secure = sec; req_write = wr;
                req_addr = {win, idx, 24'h00A5C0 + 24'(p * 52)};
                en  = sec ? m[0] : m[1];
                blk = (win == 2'd1) ? (sec ? m[3] : m[4]) :
                      (win == 2'd3) ? (sec ? m[5] : m[6]) :
                      (win == 2'd2) ? (!sec && !m[7]) : 1'b0;
                err = blk;
                qry = !err && win == 2'd0 && en;
                mnt = !err && win == 2'd2;
                fls = !err && !qry && !mnt;
                wok = !idx[1] && (idx[0] ? m[10] : m[9]);
                wout = !err && wr && (mnt || wok);
                ways = !qry ? 2'b00 : (!m[8] ? 2'b11 : (sec ? 2'b01 : 2'b10));
                @(negedge clk);
                chk("R3 valid", 32'(rsp_valid), 32'h1);
                chk((win == 2'd2) ? "R7 bus error" : "R6 bus error", 32'(rsp_buserr), 32'(err));
                chk("R4 cache query", 32'(rsp_cache_query), 32'(qry));
                chk("R4 flash bypass", 32'(rsp_flash_req), 32'(fls));
                chk("R7 maintenance", 32'(rsp_maint), 32'(mnt));
                chk("R8 way mask", 32'(rsp_way_mask), 32'(ways));
                chk("R9 write direction", 32'(rsp_write), 32'(wout));
                chk("R10 single outcome", 32'($countones({rsp_buserr, rsp_cache_query, rsp_flash_req, rsp_maint})), 32'h1);
                if (win != 2'd0) chk("R5 no query outside cached", 32'(rsp_cache_query), 32'h0);
                if (m[2]) chk("R11 no query when powered down", 32'(rsp_cache_query), 32'h0);
            end
            req_valid = 1'b0;
            @(negedge clk);
            chk("R3 idle valid", 32'(rsp_valid), 32'h0);
            chk("R3 idle outcome", 32'({rsp_buserr, rsp_cache_query, rsp_flash_req, rsp_maint, rsp_write}), 32'h0);
        end
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 195000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule